// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake pins: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents them as one 8-bit status byte. The pins arrive asynchronously and pass through a synchroniser. The upper nibble shows their present asserted state. The lower nibble holds sticky change flags that the host clears by reading the byte.

Any pending flag raises an interrupt request when the modem-status interrupt enable is high. A small two-state machine keeps the flags and the request consistent:

- `MSI_CLEAR` means no flag is held.
- The transition *capture* moves from `MSI_CLEAR` to `MSI_PENDING` when a qualified edge is seen.
- The transition *acknowledge* moves from `MSI_PENDING` back to `MSI_CLEAR` on a read strobe, but only when no edge arrives in that same cycle.
- The transition *hold* keeps the current state in every other case.

The ring-indicator flag is qualified differently from the others. It records only the end of a ring, which is the pin returning high. The other three lines record any change.

Top module: `modem_status_monitor`

## Requirements
- R1: After reset, `status` reads 8'h00 and `irq` is low.
- R2: `status[4]`, `status[5]`, `status[6]` and `status[7]` show the inverted synchronised level of `cts_n`, `dsr_n`, `ri_n` and `cd_n` respectively. A level that is 0 on the pin reads as 1. The byte follows a pin change two clock edges after the first edge that samples it.
- R3: `status[0]` (CTS), `status[1]` (DSR) and `status[3]` (CD) set on any change of their pin. The flag is visible three clock edges after the first edge that samples the change.
- R4: `status[2]` sets only when `ri_n` goes from 0 to 1. A 1-to-0 change of `ri_n` leaves it clear.
- R5: A set change flag stays set for as long as no read strobe occurs.
- R6: A cycle with `rd_stb` high clears all four change flags at the next edge. The exception is a flag whose qualified edge is detected in that same cycle: it stays set.
- R7: `irq` is high exactly when `msi_en` is high and at least one change flag is set. It drops in the same cycle that `msi_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| cd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| rd_stb | input | 1 | One-cycle strobe marking a read of the status byte |
| msi_en | input | 1 | Modem-status interrupt enable |
| status | output | 8 | Current levels in [7:4], change flags in [3:0] |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with its defaults:

- two synchroniser stages;
- the rising-only qualifier placed on the ring-indicator line alone.

With these values the latency from a pin change to a visible flag is exactly three edges. That lets the bench pulse the read strobe in the one cycle where an edge is still being detected, and so reach the same-cycle read-and-change corner. The default qualifier mask makes the asymmetry between falling and rising ring edges observable at the ports. The vector walk covers single-line changes, a multi-line change mixing both ring directions, and a cycle with no change at all.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
    localparam int unsigned LINES = 4;

    typedef enum logic {
        MSI_CLEAR   = 1'b0,
        MSI_PENDING = 1'b1
    } msi_state_e;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    // Pins idle high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mstat_edge.sv
module mstat_edge #(
    parameter int unsigned      WIDTH     = 4,
    parameter logic [WIDTH-1:0] RISE_ONLY = 4'b0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_n,
    output logic [WIDTH-1:0] edge_ev
);
    logic [WIDTH-1:0] prev_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_n <= '1;
        else        prev_n <= level_n;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        if (RISE_ONLY[i]) begin : g_rise
            // Pin returning high (end of assertion).
            assign edge_ev[i] = level_n[i] & ~prev_n[i];
        end else begin : g_any
            assign edge_ev[i] = level_n[i] ^ prev_n[i];
        end
    end
endmodule

// File: rtl/mstat_delta_fsm.sv
module mstat_delta_fsm
    import mstat_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] edge_ev,
    input  logic             rd_stb,
    input  logic             msi_en,
    output logic [WIDTH-1:0] delta,
    output logic             irq
);
    msi_state_e       state_q, state_d;
    logic [WIDTH-1:0] delta_d;

    // Flags: read clears, a same-cycle edge wins.
    always_comb begin
        delta_d = (rd_stb ? '0 : delta) | edge_ev;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MSI_CLEAR:   if (|edge_ev)              state_d = MSI_PENDING; // capture
            MSI_PENDING: if (rd_stb && !(|edge_ev)) state_d = MSI_CLEAR;   // acknowledge
            default:                                state_d = MSI_CLEAR;
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MSI_CLEAR;
            delta   <= '0;
        end else begin
            state_q <= state_d;
            delta   <= delta_d;
        end
    end

    // Output process.
    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            MSI_CLEAR:   irq = 1'b0;
            MSI_PENDING: irq = msi_en;
            default:     irq = 1'b0;
        endcase
    end

    AST_STATE_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MSI_PENDING) == (|delta)); // R7
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> msi_en); // R7
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((delta & $past(delta)) == $past(delta))); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !(|edge_ev)) |=> (delta == '0)); // R6
endmodule

// File: rtl/modem_status_monitor.sv
module modem_status_monitor
    import mstat_pkg::*;
#(
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [LINES-1:0] RISE_ONLY   = 4'b0100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       cd_n,
    input  logic       rd_stb,
    input  logic       msi_en,
    output logic [7:0] status,
    output logic       irq
);
    localparam int unsigned REG_W = 2 * LINES;

    logic [LINES-1:0] pins_n, sync_n, edge_ev, delta;
    logic [REG_W-1:0] status_w;

    assign pins_n = {cd_n, ri_n, dsr_n, cts_n};

    mstat_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pins_n), .sync_out(sync_n)
    );

    mstat_edge #(.WIDTH(LINES), .RISE_ONLY(RISE_ONLY)) u_edge (
        .clk(clk), .rst_n(rst_n), .level_n(sync_n), .edge_ev(edge_ev)
    );

    mstat_delta_fsm #(.WIDTH(LINES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .edge_ev(edge_ev), .rd_stb(rd_stb),
        .msi_en(msi_en), .delta(delta), .irq(irq)
    );

    assign status_w = {~sync_n, delta};
    assign status   = status_w;

    AST_RI_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> !$past(status[6])); // R4
    AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[3:0] != 4'b0000)); // R7
endmodule

// File: tb/test_modem_status_monitor.sv
module test_modem_status_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
    logic rd_stb = 1'b0, msi_en = 1'b0;
    logic [7:0] status;
    logic irq;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    modem_status_monitor i_modem_status_monitor (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
        .cd_n(cd_n), .rd_stb(rd_stb), .msi_en(msi_en), .status(status), .irq(irq)
    );

    // {pins {cd,ri,dsr,cts}, en, expected flags, expected irq}
    localparam logic [9:0] VEC [8] = '{
        {4'b1110, 1'b1, 4'b0001, 1'b1},
        {4'b1100, 1'b0, 4'b0010, 1'b0},
        {4'b1000, 1'b1, 4'b0000, 1'b0},
        {4'b1100, 1'b1, 4'b0100, 1'b1},
        {4'b0100, 1'b1, 4'b1000, 1'b1},
        {4'b1011, 1'b1, 4'b1011, 1'b1},
        {4'b1011, 1'b1, 4'b0000, 1'b0},
        {4'b1111, 1'b0, 4'b0100, 1'b0}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic [3:0] p);
        {cd_n, ri_n, dsr_n, cts_n} = p;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 reset state", {status, irq}, 9'h000);

        for (int k = 0; k < 8; k++) begin
            logic [3:0] p;
            logic [3:0] d;
            p = VEC[k][9:6];
            d = VEC[k][4:1];
            set_pins(p);
            msi_en = VEC[k][5];
            step(3);
            // R2 levels, R3/R4 flags, R7 request
            check($sformatf("R2 R3 R4 R7 vector %0d", k), {status, irq}, {~p, d, VEC[k][0]});
            rd_stb = 1'b1;
            step(1);
            rd_stb = 1'b0;
            check($sformatf("R6 read clears vector %0d", k), {status, irq}, {~p, 4'b0000, 1'b0});
        end

        // R2 latency: level visible after two edges, flag not yet.
        cts_n = 1'b0;
        step(2);
        check("R2 two-edge latency", {status, irq}, {4'b0001, 4'b0000, 1'b0});
        step(1);
        check("R3 three-edge flag", {status, irq}, {4'b0001, 4'b0001, 1'b0});
        rd_stb = 1'b1; step(1); rd_stb = 1'b0;

        // R6 same-cycle read and edge: DSR flag cleared, CTS flag kept.
        dsr_n = 1'b0;
        step(3);
        check("R3 DSR flag before read", {status, irq}, {4'b0011, 4'b0010, 1'b0});
        cts_n = 1'b1;
        step(2);
        rd_stb = 1'b1;
        step(1);
        rd_stb = 1'b0;
        check("R6 same-cycle edge survives", {status, irq}, {4'b0010, 4'b0001, 1'b0});

        // R5 sticky over many cycles.
        step(20);
        check("R5 flag sticky", {status, irq}, {4'b0010, 4'b0001, 1'b0});

        // R7 enable gating is immediate.
        msi_en = 1'b1;
        #1;
        check("R7 enable raises irq", {8'h00, irq}, 9'h001);
        step(1);
        msi_en = 1'b0;
        #1;
        check("R7 disable drops irq", {status, irq}, {4'b0010, 4'b0001, 1'b0});

        // R4 ring falling edge alone leaves flag clear.
        rd_stb = 1'b1; step(1); rd_stb = 1'b0;
        msi_en = 1'b1;
        ri_n = 1'b0;
        step(4);
        check("R4 ring fall ignored", {status, irq}, {4'b0110, 4'b0000, 1'b0});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule